// File: doc/BRIEF.md
# Multi-Width Subtractor with Status Flags

The block computes a destination operand minus a source operand at one of four operand widths (8, 16, 32 or 64 bits) and reports six arithmetic status flags: signed overflow, sign, zero, auxiliary (low-nibble borrow), parity and carry (unsigned borrow). The source is either a full-width source input or an immediate. In immediate mode the immediate is first sign-extended, from 8 bits or from 32 bits, and then used at the selected width.

The caller presents one operation with `in_valid` high. The operation is captured at that clock edge. In the next cycle the result and the flag vector are available on registered outputs, and `out_valid` is high for that cycle. A valid may be presented in every cycle. A small two-state controller tracks whether the output registers hold a result that is new in this cycle:
- `ST_IDLE` goes to `ST_DONE` when `in_valid` is high.
- `ST_DONE` stays in `ST_DONE` when `in_valid` is high again.
- `ST_DONE` goes back to `ST_IDLE` when `in_valid` is low.

Top module: `subw_unit`

## Requirements
- R1: `res_o` equals `dst_i` minus the effective source, taken modulo 2^N, where N is the selected width. The width code `width_i` selects N: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R2: Carry, at `flags_o[0]`, is 1 exactly when the effective source, taken as unsigned at width N, is greater than the destination taken as unsigned at width N.
- R3: Overflow, at `flags_o[5]`, is 1 exactly when the true signed difference of the two N-bit operands lies outside the range of an N-bit two's-complement number.
- R4: Sign, at `flags_o[4]`, equals bit N-1 of the result.
- R5: Zero, at `flags_o[3]`, is 1 exactly when bits N-1..0 of the result are all zero.
- R6: Auxiliary, at `flags_o[2]`, is 1 exactly when the low nibble of the source is greater than the low nibble of the destination, which is a borrow out of bit 3.
- R7: Parity, at `flags_o[1]`, is 1 exactly when bits 7..0 of the result hold an even number of ones. This holds at every width.
- R8: For N below 64, bits 63..N of `res_o` are zero.
- R9: With `imm_mode_i` high, the effective source is the immediate sign-extended to 64 bits. The extension starts from bit 7 of `imm_i` when `imm_wide_i` is 0, and from bit 31 when `imm_wide_i` is 1. `src_i` is then ignored.
- R10: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise.
- R11: After a cycle with `in_valid` low, `res_o` and `flags_o` keep their values, whatever the operand inputs do.
- R12: After reset, `out_valid`, `res_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| width_i | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64) |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source operand, used when not in immediate mode |
| imm_mode_i | input | 1 | Use the immediate as the source |
| imm_wide_i | input | 1 | Immediate width: 0 for 8 bits, 1 for 32 bits |
| imm_i | input | 32 | Immediate value |
| out_valid | output | 1 | Result registered in this cycle |
| res_o | output | 64 | Result, zero above the selected width |
| flags_o | output | 6 | {OF, SF, ZF, AF, PF, CF} |

## Verification
The assertions take the following for granted:
- The width code and the immediate controls are stable and known whenever `in_valid` is high.
- Reset is applied before the first operation.

The stimulus meets both assumptions by driving every input at the falling edge, with all fields set together. It also holds `in_valid` low for one cycle between most operations, so that the hold and valid-drop properties are exercised as well as the back-to-back path. The bench sweeps the 8-bit width almost exhaustively. It covers the wider widths with boundary operands and pseudo-random operands, and it covers both immediate sizes at all four widths.

// File: rtl/subw_pkg.sv
package subw_pkg;
    localparam int DATA_W = 64;
    localparam int IMM_W  = 32;
    localparam int FLAG_W = 6;

    localparam int F_CF = 0;
    localparam int F_PF = 1;
    localparam int F_AF = 2;
    localparam int F_ZF = 3;
    localparam int F_SF = 4;
    localparam int F_OF = 5;

    typedef enum logic [1:0] {
        OW_8  = 2'd0,
        OW_16 = 2'd1,
        OW_32 = 2'd2,
        OW_64 = 2'd3
    } opw_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_e;

    function automatic logic [DATA_W-1:0] width_mask(opw_e w);
        logic [DATA_W-1:0] m;
        unique case (w)
            OW_8:    m = {{(DATA_W-8){1'b0}},  {8{1'b1}}};
            OW_16:   m = {{(DATA_W-16){1'b0}}, {16{1'b1}}};
            OW_32:   m = {{(DATA_W-32){1'b0}}, {32{1'b1}}};
            default: m = {DATA_W{1'b1}};
        endcase
        return m;
    endfunction

    function automatic int unsigned width_msb(opw_e w);
        int unsigned b;
        unique case (w)
            OW_8:    b = 7;
            OW_16:   b = 15;
            OW_32:   b = 31;
            default: b = DATA_W - 1;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/subw_operand.sv
module subw_operand
    import subw_pkg::*;
(
    input  opw_e              width_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              imm_mode_i,
    input  logic              imm_wide_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);
    localparam int NARROW_W = 8;

    logic [DATA_W-1:0] imm_narrow;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] src_sel;
    logic [DATA_W-1:0] mask;

    always_comb begin
        imm_narrow = {{(DATA_W-NARROW_W){imm_i[NARROW_W-1]}}, imm_i[NARROW_W-1:0]};
        imm_wide   = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        if (imm_mode_i)
            src_sel = imm_wide_i ? imm_wide : imm_narrow;
        else
            src_sel = src_i;
        mask = width_mask(width_i);
        a_o  = dst_i & mask;
        b_o  = src_sel & mask;
    end

    // R8 / R9: operands never carry bits above the selected width
    always_comb begin
        assert_mask_R8: assert ((({a_o, b_o} & ~{mask, mask}) == '0) || $isunknown(width_i));
    end
endmodule

// File: rtl/subw_core.sv
module subw_core
    import subw_pkg::*;
(
    input  opw_e              width_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic [DATA_W:0]   diff;
    logic [DATA_W-1:0] res_m;
    int unsigned       msb;
    logic              a_s, b_s, r_s;

    always_comb begin
        diff  = {1'b0, a_i} - {1'b0, b_i};
        res_m = diff[DATA_W-1:0] & width_mask(width_i);
        msb   = width_msb(width_i);
        a_s   = a_i[msb];
        b_s   = b_i[msb];
        r_s   = res_m[msb];
        res_o = res_m;
        flags_o        = '0;
        flags_o[F_CF]  = (a_i < b_i);
        flags_o[F_PF]  = ~^res_m[7:0];
        flags_o[F_AF]  = (a_i[3:0] < b_i[3:0]);
        flags_o[F_ZF]  = (res_m == '0);
        flags_o[F_SF]  = r_s;
        flags_o[F_OF]  = (a_s != b_s) && (r_s != a_s);
    end
endmodule

// File: rtl/subw_unit.sv
module subw_unit
    import subw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        width_i,
    input  logic [63:0]       dst_i,
    input  logic [63:0]       src_i,
    input  logic              imm_mode_i,
    input  logic              imm_wide_i,
    input  logic [31:0]       imm_i,
    output logic              out_valid,
    output logic [63:0]       res_o,
    output logic [5:0]        flags_o
);
    ctl_state_e        state_q, state_d;
    opw_e              width_e;
    opw_e              width_q;
    logic [DATA_W-1:0] a_w, b_w, res_w;
    logic [FLAG_W-1:0] flags_w;
    logic [DATA_W-1:0] res_q;
    logic [FLAG_W-1:0] flags_q;

    assign width_e = opw_e'(width_i);

    subw_operand u_operand (
        .width_i   (width_e),
        .dst_i     (dst_i),
        .src_i     (src_i),
        .imm_mode_i(imm_mode_i),
        .imm_wide_i(imm_wide_i),
        .imm_i     (imm_i),
        .a_o       (a_w),
        .b_o       (b_w)
    );

    subw_core u_core (
        .width_i(width_e),
        .a_i    (a_w),
        .b_i    (b_w),
        .res_o  (res_w),
        .flags_o(flags_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_DONE;
            ST_DONE: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            width_q <= OW_8;
        end else if (in_valid) begin
            res_q   <= res_w;
            flags_q <= flags_w;
            width_q <= width_e;
        end
    end

    assign out_valid = (state_q == ST_DONE);
    assign res_o     = res_q;
    assign flags_o   = flags_q;

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_o) && $stable(flags_o)));
    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_o[F_ZF] == (res_o == '0)));
    assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags_o[F_PF] == ~^res_o[7:0]));
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && width_q != OW_64) |-> ((res_o & ~width_mask(width_q)) == '0));
endmodule

// File: tb/subw_unit_bench.sv
`timescale 1ns/1ps
module subw_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  width_i = '0;
    logic [63:0] dst_i = '0, src_i = '0;
    logic        imm_mode_i = 1'b0, imm_wide_i = 1'b0;
    logic [31:0] imm_i = '0;
    logic        out_valid;
    logic [63:0] res_o;
    logic [5:0]  flags_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    subw_unit u_subw_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_i(width_i),
        .dst_i(dst_i), .src_i(src_i), .imm_mode_i(imm_mode_i),
        .imm_wide_i(imm_wide_i), .imm_i(imm_i),
        .out_valid(out_valid), .res_o(res_o), .flags_o(flags_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] w);
        return 8 << w;
    endfunction

    // drive one op, check its registered outputs one cycle later
    task automatic run_op(input logic [1:0] w, input logic [63:0] d, input logic [63:0] s,
                          input bit im, input bit iw, input logic [31:0] iv);
        int n;
        logic [63:0] mask, a, b, er;
        logic signed [65:0] sa, sb, sd;
        bit ecf, eof, esf, ezf, eaf, epf;
        n = nbits(w);
        mask = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        a = d & mask;
        if (im) b = iw ? {{32{iv[31]}}, iv} : {{56{iv[7]}}, iv[7:0]};
        else    b = s;
        b = b & mask;
        er  = (a - b) & mask;
        ecf = (a < b);
        sa  = $signed({2'b00, a} << (66 - n)) >>> (66 - n);
        sb  = $signed({2'b00, b} << (66 - n)) >>> (66 - n);
        sd  = sa - sb;
        eof = !((sd >>> (n - 1)) == 0 || (sd >>> (n - 1)) == -1);
        esf = er[n-1];
        ezf = (er == 0);
        eaf = (a[3:0] < b[3:0]);
        epf = ($countones(er[7:0]) % 2) == 0;
        @(negedge clk);
        width_i = w; dst_i = d; src_i = s; imm_mode_i = im; imm_wide_i = iw; imm_i = iv;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R10 out_valid after op", {63'd0, out_valid}, 64'd1);
        chk((res_o & mask) == er, im ? "R9 R1 result" : "R1 result", res_o, er);
        chk((res_o & ~mask) == 0, "R8 upper bits", res_o, er);
        chk(flags_o[0] == ecf, "R2 carry", {58'd0, flags_o}, {63'd0, ecf});
        chk(flags_o[5] == eof, "R3 overflow", {58'd0, flags_o}, {63'd0, eof});
        chk(flags_o[4] == esf, "R4 sign", {58'd0, flags_o}, {63'd0, esf});
        chk(flags_o[3] == ezf, "R5 zero", {58'd0, flags_o}, {63'd0, ezf});
        chk(flags_o[2] == eaf, "R6 aux", {58'd0, flags_o}, {63'd0, eaf});
        chk(flags_o[1] == epf, "R7 parity", {58'd0, flags_o}, {63'd0, epf});
    endtask

    logic [63:0] corners [10];

    initial begin
        corners[0] = 64'h0;                corners[1] = 64'h1;
        corners[2] = 64'h7F;               corners[3] = 64'h80;
        corners[4] = 64'h7FFF;             corners[5] = 64'h8000;
        corners[6] = 64'h7FFF_FFFF;        corners[7] = 64'h8000_0000;
        corners[8] = 64'h7FFF_FFFF_FFFF_FFFF; corners[9] = 64'hFFFF_FFFF_FFFF_FFFF;

        repeat (3) @(negedge clk);
        // R12 reset state
        chk(out_valid == 0, "R12 reset out_valid", {63'd0, out_valid}, 0);
        chk(res_o == 0, "R12 reset result", res_o, 0);
        chk(flags_o == 0, "R12 reset flags", {58'd0, flags_o}, 0);
        rst_n = 1'b1;

        // near-exhaustive 8-bit sweep
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s += 3)
                run_op(2'd0, 64'(d) | 64'hA500, 64'(s) | 64'h5A00, 1'b0, 1'b0, 32'd0);

        // wider widths: boundary grid and random
        for (int w = 1; w < 4; w++) begin
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run_op(2'(w), corners[i], corners[j], 1'b0, 1'b0, 32'd0);
            for (int k = 0; k < 400; k++)
                run_op(2'(w), {$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 1'b0, 32'd0);
        end

        // immediates: R9, both sizes, all widths, src must be ignored
        for (int w = 0; w < 4; w++)
            for (int k = 0; k < 60; k++) begin
                logic [31:0] iv;
                iv = (k < 4) ? ((k == 0) ? 32'h80 : (k == 1) ? 32'h7F : (k == 2) ? 32'h8000_0000 : 32'hFFFF_FFFF)
                             : $urandom;
                run_op(2'(w), {$urandom, $urandom}, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, k[0], iv);
            end

        // R11 hold with idle cycle and changing operands; R10 valid low
        run_op(2'd3, 64'd5, 64'd9, 1'b0, 1'b0, 32'd0);
        begin
            logic [63:0] r0; logic [5:0] f0;
            r0 = res_o; f0 = flags_o;
            @(negedge clk);
            dst_i = 64'h1234; src_i = 64'h1; width_i = 2'd1;
            chk(out_valid == 0, "R10 out_valid low when idle", {63'd0, out_valid}, 0);
            @(negedge clk);
            chk(res_o == r0, "R11 result held", res_o, r0);
            chk(flags_o == f0, "R11 flags held", {58'd0, flags_o}, {58'd0, f0});
            chk(out_valid == 0, "R10 out_valid still low", {63'd0, out_valid}, 0);
        end

        // R10 back-to-back: valid stays high
        @(negedge clk);
        width_i = 2'd0; dst_i = 64'd3; src_i = 64'd1; imm_mode_i = 0; in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid == 1, "R10 first of pair", {63'd0, out_valid}, 1);
        chk(res_o == 64'd2, "R1 first of pair", res_o, 64'd2);
        dst_i = 64'd1; src_i = 64'd3;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1, "R10 second of pair", {63'd0, out_valid}, 1);
        chk(res_o == 64'hFE, "R1 second of pair", res_o, 64'hFE);
        @(negedge clk);
        chk(out_valid == 0, "R10 after pair", {63'd0, out_valid}, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20ns * 190000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule